// File: doc/BRIEF.md
# UART Data and Status Register Front End

This block sits between a processor bus and the serial engines of a UART. A single data address serves both directions. A write there fills a one-entry transmit holding buffer. A read there returns the oldest character of a small receive FIFO and removes it from the FIFO. A status address reports whether received data is waiting, whether the transmitter has gone idle, whether the holding buffer can take a write, and whether a received character was lost. A control address holds the interrupt enables.

On the line side, the block offers the held character to a transmit shift engine. The character moves across when the transmitter is enabled and the engine is not busy. The block also accepts characters from a receive engine through a valid strobe. Character length can be 5, 6, 7 or 8 bits, and data bits above that length are forced to zero in both directions. Baud timing, framing, parity and line error detection belong to the engines and are not part of this block.

Top module: `uart_regfront`

## Requirements
- R1: After reset, status reads 0x20: only data-register-empty (bit 5) is set. The control register reads 0, all interrupt outputs are low, and `tx_load` is low.
- R2: A write to the data address (0) is accepted only while data-register-empty is set, and accepting it clears that flag. A data write made while the flag is clear is discarded, and the earlier character is the one later handed to the engine.
- R3: `tx_load` is high, with `tx_data` showing the held character, in every cycle where the buffer is full, `tx_en` is high and `tx_busy` is low. The buffer empties at that clock edge, so data-register-empty reads 1 in the following cycle.
- R4: Transmit-complete (status bit 6) sets on a `tx_done` pulse that arrives while the holding buffer is empty. A `tx_done` pulse that arrives while the buffer is full leaves it clear.
- R5: Transmit-complete clears on a `txc_ack` pulse or on a write to the status address (1) with bit 6 set. A status write with bit 6 clear leaves it unchanged.
- R6: For `char_len` codes 0, 1, 2 and 3 (5, 6, 7 and 8 data bits), transmit data bits at or above the character length are presented as zero on `tx_data`.
- R7: The receive FIFO holds two characters and returns them in arrival order. Each read of the data address removes one character. A read while the FIFO is empty returns 0.
- R8: Receive-complete (status bit 7) is 1 exactly while the receive FIFO holds at least one character.
- R9: While `rx_en` is low, the receive FIFO and the overrun bit are emptied, and `rx_valid` strobes are ignored.
- R10: A character that arrives while the FIFO already holds two is dropped, and overrun (status bit 3) is set. Overrun clears when a read empties the FIFO.
- R11: Received characters are stored with bits at or above the character length in force at arrival set to zero.
- R12: The control register (address 2) is readable and writable in bits 7, 6 and 5. Bit 7 enables `irq_rxc`, bit 6 enables `irq_txc` and bit 5 enables `irq_dre`. Each interrupt output is its status flag ANDed with its enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register address: 0 data, 1 status, 2 control |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; pops the FIFO when addressing data |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the current address, combinational |
| char_len | input | 2 | Character length code, 0..3 for 5..8 bits |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable; low flushes the receive FIFO |
| tx_load | output | 1 | Transfer of the held character to the shift engine |
| tx_data | output | DATA_W | Held character, masked to the character length |
| tx_busy | input | 1 | Shift engine is occupied |
| tx_done | input | 1 | Pulse: a frame has left the shift engine |
| rx_valid | input | 1 | Pulse: a received character is on rx_data |
| rx_data | input | DATA_W | Received character |
| txc_ack | input | 1 | Transmit-complete interrupt acknowledge |
| irq_rxc | output | 1 | Receive-complete interrupt |
| irq_txc | output | 1 | Transmit-complete interrupt |
| irq_dre | output | 1 | Data-register-empty interrupt |

## Verification
A wrong receive count or a bad pointer shows in the first status read, through receive-complete or overrun. It also shows in the first data read, as a character out of order, duplicated or left unmasked. A holding buffer stuck full or empty shows in the same cycle as the access, through `tx_load` and data-register-empty. A transmit-complete flag that sets or clears on the wrong event shows at the next status read and at `irq_txc`. The sweeps over every character length and a spread of byte values reach each of these faults within a few cycles of its cause.

// File: rtl/uart_regfront_pkg.sv
package uart_regfront_pkg;

   localparam int REG_DATA = 0;
   localparam int REG_STAT = 1;
   localparam int REG_CTRL = 2;

   localparam int STAT_RXC = 7;
   localparam int STAT_TXC = 6;
   localparam int STAT_DRE = 5;
   localparam int STAT_OVR = 3;

   typedef enum logic [1:0] {
      LEN_5 = 2'd0,
      LEN_6 = 2'd1,
      LEN_7 = 2'd2,
      LEN_8 = 2'd3
   } char_len_e;

   function automatic logic [7:0] char_mask(input logic [1:0] len);
      return 8'hFF >> (2'd3 - len);
   endfunction

endpackage

// File: rtl/uart_txbuf.sv
module uart_txbuf #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              tx_en,
   input  logic              tx_busy,
   input  logic              tx_done,
   input  logic              txc_clr,
   output logic              dre,
   output logic              txc,
   output logic              tx_load,
   output logic [DATA_W-1:0] tx_data
);

   logic              full_q;
   logic [DATA_W-1:0] hold_q;
   logic              txc_q;

   assign tx_load = full_q & tx_en & ~tx_busy;
   assign tx_data = hold_q;
   assign dre     = ~full_q;
   assign txc     = txc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         hold_q <= '0;
      end else if (wr_req && !full_q) begin
         hold_q <= wr_data;
         full_q <= 1'b1;
      end else if (tx_load) begin
         full_q <= 1'b0;
      end
   end

   // completion wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         txc_q <= 1'b0;
      else if (tx_done && !full_q)
         txc_q <= 1'b1;
      else if (txc_clr)
         txc_q <= 1'b0;
   end

   assert_load_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |=> dre);

   assert_full_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !dre && !tx_load) |=> ($stable(tx_data) && !dre));

   assert_txc_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_done && dre) |=> txc);

   assert_txc_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (txc_clr && !tx_done) |=> !txc);

endmodule

// File: rtl/uart_rxfifo.sv
module uart_rxfifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic              not_empty,
   output logic              overrun
);

   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [CNT_W-1:0] count_q;
   logic             ovr_q;
   logic             pop_ok, push_ok, drop, space;

   assign pop_ok  = pop && (count_q != '0);
   assign space   = (count_q < CNT_W'(DEPTH)) || pop_ok;
   assign push_ok = rx_en && push && space;
   assign drop    = rx_en && push && !space;

   assign not_empty = (count_q != '0);
   assign overrun   = ovr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count_q <= '0;
      else if (!rx_en)
         count_q <= '0;
      else
         count_q <= count_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ovr_q <= 1'b0;
      else if (!rx_en)
         ovr_q <= 1'b0;
      else if (drop)
         ovr_q <= 1'b1;
      else if (pop_ok && (count_q == CNT_W'(1)) && !push_ok)
         ovr_q <= 1'b0;
   end

   generate
      if (DEPTH == 1) begin : g_single
         logic [DATA_W-1:0] slot_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               slot_q <= '0;
            else if (push_ok)
               slot_q <= push_data;
         end
         assign head = slot_q;
      end else begin : g_ring
         localparam int PTR_W = $clog2(DEPTH);
         logic [DATA_W-1:0] mem_q [DEPTH];
         logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;

         function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
            return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
         endfunction

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wr_ptr_q <= '0;
               rd_ptr_q <= '0;
            end else if (!rx_en) begin
               wr_ptr_q <= '0;
               rd_ptr_q <= '0;
            end else begin
               if (push_ok) wr_ptr_q <= bump(wr_ptr_q);
               if (pop_ok)  rd_ptr_q <= bump(rd_ptr_q);
            end
         end

         always_ff @(posedge clk) begin
            if (push_ok) mem_q[wr_ptr_q] <= push_data;
         end

         assign head = mem_q[rd_ptr_q];
      end
   endgenerate

   assert_depth_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CNT_W'(DEPTH));

   assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> (!not_empty && !overrun));

   assert_drop_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> (overrun && $stable(count_q)));

   assert_pop_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && pop && !push && (count_q == CNT_W'(1))) |=> !not_empty);

endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
   import uart_regfront_pkg::*;
#(
   parameter int ADDR_W   = 2,
   parameter int DATA_W   = 8,
   parameter int RX_DEPTH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [1:0]        char_len,
   input  logic              tx_en,
   input  logic              rx_en,
   output logic              tx_load,
   output logic [DATA_W-1:0] tx_data,
   input  logic              tx_busy,
   input  logic              tx_done,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              txc_ack,
   output logic              irq_rxc,
   output logic              irq_txc,
   output logic              irq_dre
);

   initial begin
      assert_data_width: assert (DATA_W == 8)
         else $error("uart_regfront: DATA_W must be 8");
      assert_addr_width: assert (ADDR_W >= 2)
         else $error("uart_regfront: ADDR_W must be at least 2");
      assert_rx_depth: assert (RX_DEPTH >= 1)
         else $error("uart_regfront: RX_DEPTH must be at least 1");
   end

   logic sel_data, sel_stat, sel_ctrl;
   logic dre, txc, rxc, ovr;
   logic txc_clr;
   logic [DATA_W-1:0] len_mask, rx_head;
   logic [2:0] ien_q;

   assign sel_data = (bus_addr == ADDR_W'(REG_DATA));
   assign sel_stat = (bus_addr == ADDR_W'(REG_STAT));
   assign sel_ctrl = (bus_addr == ADDR_W'(REG_CTRL));
   assign len_mask = char_mask(char_len);
   assign txc_clr  = txc_ack | (bus_wr & sel_stat & bus_wdata[STAT_TXC]);

   uart_txbuf #(.DATA_W(DATA_W)) i_txbuf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_req  (bus_wr & sel_data),
      .wr_data (bus_wdata & len_mask),
      .tx_en   (tx_en),
      .tx_busy (tx_busy),
      .tx_done (tx_done),
      .txc_clr (txc_clr),
      .dre     (dre),
      .txc     (txc),
      .tx_load (tx_load),
      .tx_data (tx_data)
   );

   uart_rxfifo #(.DATA_W(DATA_W), .DEPTH(RX_DEPTH)) i_rxfifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_en     (rx_en),
      .push      (rx_valid),
      .push_data (rx_data & len_mask),
      .pop       (bus_rd & sel_data),
      .head      (rx_head),
      .not_empty (rxc),
      .overrun   (ovr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ien_q <= '0;
      else if (bus_wr && sel_ctrl)
         ien_q <= bus_wdata[7:5];
   end

   always_comb begin
      bus_rdata = '0;
      if (sel_data) begin
         if (rxc) bus_rdata = rx_head;
      end else if (sel_stat) begin
         bus_rdata[STAT_RXC] = rxc;
         bus_rdata[STAT_TXC] = txc;
         bus_rdata[STAT_DRE] = dre;
         bus_rdata[STAT_OVR] = ovr;
      end else if (sel_ctrl) begin
         bus_rdata[7:5] = ien_q;
      end
   end

   assign irq_rxc = rxc & ien_q[2];
   assign irq_txc = txc & ien_q[1];
   assign irq_dre = dre & ien_q[0];

   assert_irq_needs_enable_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel_ctrl && !bus_wdata[7]) |=> !irq_rxc);

endmodule

// File: tb/test_uart_regfront.sv
module test_uart_regfront;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = '0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [1:0] char_len = 2'd3;
   logic       tx_en = 1'b0, rx_en = 1'b0;
   logic       tx_load;
   logic [7:0] tx_data;
   logic       tx_busy = 1'b0, tx_done = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = '0;
   logic       txc_ack = 1'b0;
   logic       irq_rxc, irq_txc, irq_dre;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   uart_regfront i_uart_regfront (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .char_len(char_len), .tx_en(tx_en), .rx_en(rx_en),
      .tx_load(tx_load), .tx_data(tx_data), .tx_busy(tx_busy),
      .tx_done(tx_done), .rx_valid(rx_valid), .rx_data(rx_data),
      .txc_ack(txc_ack), .irq_rxc(irq_rxc), .irq_txc(irq_txc),
      .irq_dre(irq_dre)
   );

   function automatic logic [7:0] masked(input logic [7:0] d, input int len);
      return d & 8'((1 << (5 + len)) - 1);
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic rx_char(input logic [7:0] d);
      rx_data = d; rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();

      // R1 reset state
      rd(2'd1, r); check("R1 status", r, 8'h20);
      rd(2'd2, r); check("R1 control", r, 8'h00);
      check("R1 irqs/load", {4'd0, irq_rxc, irq_txc, irq_dre, tx_load}, 8'h00);

      // R12 control register and data-register-empty interrupt
      wr(2'd2, 8'hFF);
      rd(2'd2, r); check("R12 control readback", r, 8'hE0);
      check("R12 irq_dre", {7'd0, irq_dre}, 8'h01);
      check("R12 irq_rxc idle", {7'd0, irq_rxc}, 8'h00);

      // R3/R6 sweep of lengths and values with the engine idle
      tx_en = 1'b1;
      for (int len = 0; len < 4; len++) begin
         for (int v = 0; v < 256; v += 17) begin
            char_len = 2'(len);
            wr(2'd0, 8'(v));
            check("R3 load", {7'd0, tx_load}, 8'h01);
            check("R6 tx mask", tx_data, masked(8'(v), len));
            tick();
            rd(2'd1, r); check("R3 emptied", r, 8'h20);
         end
      end

      // R2 write refused while full
      char_len = 2'd3;
      tx_en = 1'b0;
      wr(2'd0, 8'hA5);
      rd(2'd1, r); check("R2 dre clear", r, 8'h00);
      wr(2'd0, 8'h3C);
      check("R3 disabled no load", {7'd0, tx_load}, 8'h00);
      tx_en = 1'b1;
      #1 check("R3 enable load", {7'd0, tx_load}, 8'h01);
      check("R2 first kept", tx_data, 8'hA5);
      tick();

      // R3 busy holds; R4 done while full does not set
      tx_busy = 1'b1;
      wr(2'd0, 8'h81);
      check("R3 busy no load", {7'd0, tx_load}, 8'h00);
      tx_done = 1'b1; tick(); tx_done = 1'b0;
      rd(2'd1, r); check("R4 done while full", r, 8'h00);
      tx_busy = 1'b0;
      #1 check("R3 idle load", {7'd0, tx_load}, 8'h01);
      check("R3 data", tx_data, 8'h81);
      tick();
      tx_busy = 1'b1; tick();
      tx_done = 1'b1; tick(); tx_done = 1'b0;
      rd(2'd1, r); check("R4 txc set", r, 8'h60);
      check("R12 irq_txc", {7'd0, irq_txc}, 8'h01);

      // R5 clearing
      wr(2'd1, 8'hBF);
      rd(2'd1, r); check("R5 zero bit keeps", r, 8'h60);
      wr(2'd1, 8'h40);
      rd(2'd1, r); check("R5 write one clears", r, 8'h20);
      tx_done = 1'b1; tick(); tx_done = 1'b0;
      rd(2'd1, r); check("R4 set again", r, 8'h60);
      txc_ack = 1'b1; tick(); txc_ack = 1'b0;
      rd(2'd1, r); check("R5 ack clears", r, 8'h20);
      check("R12 irq_txc low", {7'd0, irq_txc}, 8'h00);
      tx_busy = 1'b0;

      // R7/R8/R11 receive sweep
      rx_en = 1'b1;
      for (int len = 0; len < 4; len++) begin
         for (int v = 3; v < 256; v += 29) begin
            char_len = 2'(len);
            rx_char(8'(v));
            rx_char(8'(v) ^ 8'h5A);
            char_len = 2'(3 - len);
            rd(2'd1, r); check("R8 rxc set", r, 8'hA0);
            check("R12 irq_rxc", {7'd0, irq_rxc}, 8'h01);
            rd(2'd0, r); check("R11 first", r, masked(8'(v), len));
            rd(2'd0, r); check("R7 second", r, masked(8'(v) ^ 8'h5A, len));
            rd(2'd1, r); check("R8 rxc clear", r, 8'h20);
         end
      end
      char_len = 2'd3;
      rd(2'd0, r); check("R7 empty read", r, 8'h00);

      // R10 overrun
      rx_char(8'h11); rx_char(8'h22); rx_char(8'h33);
      rd(2'd1, r); check("R10 overrun set", r, 8'hA8);
      rd(2'd0, r); check("R10 oldest", r, 8'h11);
      rd(2'd1, r); check("R10 still set", r, 8'hA8);
      rd(2'd0, r); check("R10 second", r, 8'h22);
      rd(2'd1, r); check("R10 cleared", r, 8'h20);
      rd(2'd0, r); check("R10 third dropped", r, 8'h00);

      // R9 flush on disable
      rx_char(8'h01); rx_char(8'h02); rx_char(8'h03);
      rx_en = 1'b0; tick();
      rd(2'd1, r); check("R9 flushed", r, 8'h20);
      rx_char(8'h07);
      rx_en = 1'b1; tick();
      rd(2'd1, r); check("R9 ignored while off", r, 8'h20);
      rd(2'd0, r); check("R9 empty data", r, 8'h00);

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule